// File: doc/BRIEF.md
# Sync Pulse Normalizer and Combiner

This block takes the separate, positive-going horizontal and vertical sync signals of an older progressive 312-line video source and rebuilds them to broadcast-standard widths. The source lines repeat every 64 µs (15.625 kHz) and each field holds exactly 312 lines, with no half line. Its horizontal pulses last roughly 14 µs and its vertical pulses roughly 16 lines, far longer than a display expects. Each raw input is brought into the sample-clock domain through a synchronizer. A counter-based one-shot then fires on the input's leading edge and produces a pulse of fixed, jitter-free width. The horizontal target is 4.7 µs (±0.2 µs). The vertical target is 2.5 to 3 lines, with 3 lines as the default.

The two shortened pulses are merged into one active-low composite sync with a NOR: composite sync goes low whenever either pulse is active. This merge only gives a clean composite signal if the vertical sync changes state on horizontal leading edges. For that reason, the vertical one-shot can measure its width in counted horizontal leading edges instead of clock cycles, so that its trailing edge also falls on a line boundary.

With a 27 MHz sample clock, the defaults are a horizontal width of 127 cycles and a vertical width of 5184 cycles, which is three lines.

Top module: `sync_norm_top`

## Requirements
- R1: While `rst` is high, `hsync_out` and `vsync_out` are low and `csync_n` is high, whatever the raw inputs do.
- R2: A rising edge on `hsync_raw` produces a `hsync_out` pulse exactly `H_WIDTH` clock cycles long, even if the raw pulse is longer.
- R3: The first high cycle of an output pulse comes exactly 4 clock cycles after the raw input was first sampled high. The 4 cycles are two synchronizer stages, the one-shot register and the output register. The latency is the same for both paths.
- R4: While a one-shot is running, further rising edges on its raw input and a raw input that stays high neither retrigger nor lengthen the pulse.
- R5: With `V_UNIT` set to cycle counting (value 0), a rising edge on `vsync_raw` produces a `vsync_out` pulse exactly `V_WIDTH` cycles long.
- R6: With `V_UNIT` set to line counting (value 1), `vsync_out` starts with the horizontal leading edge that coincides with its trigger. It lasts until the `V_WIDTH`-th following horizontal leading edge, and falls in the same cycle that `hsync_out` rises.
- R7: `csync_n` is low exactly in the cycles where `hsync_out` or `vsync_out` is high, and high otherwise.
- R8: Once a pulse has ended, the next rising edge on the raw input triggers a fresh pulse of full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_raw | input | 1 | Raw horizontal sync from the source, active high, asynchronous |
| vsync_raw | input | 1 | Raw vertical sync from the source, active high, asynchronous |
| hsync_out | output | 1 | Reshaped horizontal sync, active high |
| vsync_out | output | 1 | Reshaped vertical sync, active high |
| csync_n | output | 1 | Composite sync, active low, NOR of the two reshaped pulses |

## Verification
The horizontal one-shot is driven with a single long raw pulse, which shows that the output width is independent of the input width. It is also driven with a short pulse followed by a second edge inside the running window, which separates a correct one-shot from a retriggerable one. A further case places a second edge after the window has closed, which separates re-arming from a one-shot that locks up.

A wide vertical pulse is overlaid with horizontal pulses both inside and outside it. Counting the low cycles of composite sync then separates a NOR merge from an AND merge or from a single-path merge. A line-counting instance is fed a periodic horizontal train with a coincident vertical edge. This shows whether the vertical width follows the line edges rather than the clock, and whether its trailing edge lands on a horizontal leading edge.

// File: rtl/sync_norm_pkg.sv
package sync_norm_pkg;
  // How the vertical one-shot measures its width.
  typedef enum logic {
    VW_CYCLES = 1'b0,  // width counted in sample-clock cycles
    VW_LINES  = 1'b1   // width counted in horizontal leading edges
  } vwidth_unit_e;
endpackage

// File: rtl/sn_sync_edge.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module sn_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/sn_oneshot.sv
// Non-retriggerable counter one-shot. The pulse starts one cycle after
// trig and ends after WIDTH cycles in which tick was high.
module sn_oneshot #(
  parameter int WIDTH = 127
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic tick,
  output logic active
);
  localparam int CW = (WIDTH < 2) ? 1 : $clog2(WIDTH + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      if (trig) begin
        active <= 1'b1;
        remain <= CW'(WIDTH - 1);
      end
    end else if (tick) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/sync_norm_top.sv
module sync_norm_top
  import sync_norm_pkg::*;
#(
  parameter int           H_WIDTH     = 127,       // 4.7 us at 27 MHz
  parameter vwidth_unit_e V_UNIT      = VW_CYCLES,
  parameter int           V_WIDTH     = 5184,      // 3 lines at 27 MHz
  parameter int           SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_raw,
  input  logic vsync_raw,
  output logic hsync_out,
  output logic vsync_out,
  output logic csync_n
);
  logic h_rise, v_rise, v_tick;
  logic h_pulse, v_pulse;

  // Equal synchronizer depth on both paths keeps their alignment.
  sn_sync_edge #(.STAGES(SYNC_STAGES)) u_h_sync (
    .clk(clk), .rst(rst), .din(hsync_raw), .rise(h_rise)
  );
  sn_sync_edge #(.STAGES(SYNC_STAGES)) u_v_sync (
    .clk(clk), .rst(rst), .din(vsync_raw), .rise(v_rise)
  );

  sn_oneshot #(.WIDTH(H_WIDTH)) u_h_shot (
    .clk(clk), .rst(rst), .trig(h_rise), .tick(1'b1), .active(h_pulse)
  );

  generate
    if (V_UNIT == VW_LINES) begin : g_vtick_lines
      assign v_tick = h_rise;
    end else begin : g_vtick_cycles
      assign v_tick = 1'b1;
    end
  endgenerate

  sn_oneshot #(.WIDTH(V_WIDTH)) u_v_shot (
    .clk(clk), .rst(rst), .trig(v_rise), .tick(v_tick), .active(v_pulse)
  );

  // Registered outputs, all taken from the same stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
      csync_n   <= 1'b1;
    end else begin
      hsync_out <= h_pulse;
      vsync_out <= v_pulse;
      csync_n   <= ~(h_pulse | v_pulse);
    end
  end
endmodule

// File: rtl/sync_norm_chk.sv
module sync_norm_chk
  import sync_norm_pkg::*;
#(
  parameter int           H_WIDTH = 127,
  parameter vwidth_unit_e V_UNIT  = VW_CYCLES,
  parameter int           V_WIDTH = 5184
) (
  input logic clk,
  input logic rst,
  input logic hsync_raw,
  input logic vsync_raw,
  input logic hsync_out,
  input logic vsync_out,
  input logic csync_n
);
  logic [2:0] since_rst;
  int         h_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      h_run     <= 0;
    end else begin
      if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
      h_run <= hsync_out ? h_run + 1 : 0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!hsync_out && !vsync_out && csync_n));

  // R2
  h_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_out) |-> (h_run == H_WIDTH));

  // R3
  h_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hsync_out) && since_rst >= 3'd6) |->
      ($past(hsync_raw, 4) && !$past(hsync_raw, 5)));

  // R3
  v_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsync_out) && since_rst >= 3'd6) |->
      ($past(vsync_raw, 4) && !$past(vsync_raw, 5)));

  // R7
  csync_low_chk: assert property (@(posedge clk) disable iff (rst)
    (hsync_out || vsync_out) |-> !csync_n);

  // R7
  csync_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!hsync_out && !vsync_out) |-> csync_n);

  generate
    if (V_UNIT == VW_LINES) begin : g_lines
      // R6
      v_line_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_out) |-> $rose(hsync_out));
    end else begin : g_cycles
      int v_run;
      always_ff @(posedge clk) begin
        if (rst) v_run <= 0;
        else     v_run <= vsync_out ? v_run + 1 : 0;
      end
      // R5
      v_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_out) |-> (v_run == V_WIDTH));
    end
  endgenerate
endmodule

bind sync_norm_top sync_norm_chk #(
  .H_WIDTH(H_WIDTH), .V_UNIT(V_UNIT), .V_WIDTH(V_WIDTH)
) u_chk (
  .clk(clk), .rst(rst), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
  .hsync_out(hsync_out), .vsync_out(vsync_out), .csync_n(csync_n)
);

// File: tb/tb_sync_norm_top.sv
module tb_sync_norm_top;
  import sync_norm_pkg::*;

  localparam int HW = 8;
  localparam int VW = 100;
  localparam int VL = 3;
  localparam int LINE = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hr  = 1'b0;
  logic vr  = 1'b0;
  logic h_o, v_o, cs, hl_o, vl_o, csl;

  always #5 clk = ~clk;

  sync_norm_top #(.H_WIDTH(HW), .V_UNIT(VW_CYCLES), .V_WIDTH(VW)) dut (
    .clk(clk), .rst(rst), .hsync_raw(hr), .vsync_raw(vr),
    .hsync_out(h_o), .vsync_out(v_o), .csync_n(cs)
  );

  sync_norm_top #(.H_WIDTH(HW), .V_UNIT(VW_LINES), .V_WIDTH(VL)) dut_l (
    .clk(clk), .rst(rst), .hsync_raw(hr), .vsync_raw(vr),
    .hsync_out(hl_o), .vsync_out(vl_o), .csync_n(csl)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // statistics over one window
  int h_first, h_cnt, h_rises, v_first, v_cnt, cs_low, cs_bad;
  int hl_cnt, hl_rises, vl_first, vl_cnt, vl_aligned;
  bit h_p, v_p, hl_p, vl_p;

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_stats();
    h_first = -1; h_cnt = 0; h_rises = 0; v_first = -1; v_cnt = 0;
    cs_low = 0; cs_bad = 0; hl_cnt = 0; hl_rises = 0; vl_first = -1;
    vl_cnt = 0; vl_aligned = 0;
    h_p = 0; v_p = 0; hl_p = 0; vl_p = 0;
  endtask

  task automatic sample(int i);
    if (h_o) begin
      h_cnt++;
      if (!h_p) begin h_rises++; if (h_first < 0) h_first = i; end
    end
    if (v_o) begin
      v_cnt++;
      if (!v_p && v_first < 0) v_first = i;
    end
    if (cs !== !(h_o | v_o)) cs_bad++;
    if (csl !== !(hl_o | vl_o)) cs_bad++;
    if (!cs) cs_low++;
    if (hl_o) begin hl_cnt++; if (!hl_p) hl_rises++; end
    if (vl_o) begin
      vl_cnt++;
      if (!vl_p && vl_first < 0) vl_first = i;
    end
    if (!vl_o && vl_p && hl_o && !hl_p) vl_aligned++;
    h_p = h_o; v_p = v_o; hl_p = hl_o; vl_p = vl_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hr = 1'b0; vr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    clr_stats();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; hr = 1'b1; vr = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R1", "hsync_out in reset", int'(h_o), 0);
    check_eq("R1", "vsync_out in reset", int'(v_o), 0);
    check_eq("R1", "csync_n in reset", int'(cs), 1);
    check_eq("R1", "line-mode vsync_out in reset", int'(vl_o), 0);
    hr = 1'b0; vr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R1", "hsync_out idle after reset", int'(h_o), 0);
  endtask

  task automatic t_hwidth();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sample(i);
      hr = (i < 20);
    end
    check_eq("R3", "hsync first high sample", h_first, 4);
    check_eq("R2", "hsync width for long raw pulse", h_cnt, HW);
    check_eq("R2", "hsync pulse count", h_rises, 1);
    check_eq("R7", "csync mismatches", cs_bad, 0);
  endtask

  task automatic t_retrig();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sample(i);
      hr = (i < 3) || (i >= 5 && i < 15);
    end
    check_eq("R4", "pulses with edge inside window", h_rises, 1);
    check_eq("R4", "width with edge inside window", h_cnt, HW);
  endtask

  task automatic t_rearm();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sample(i);
      hr = (i < 2) || (i >= 12 && i < 14);
    end
    check_eq("R8", "pulses after re-arm", h_rises, 2);
    check_eq("R8", "total high cycles", h_cnt, 2 * HW);
    check_eq("R3", "first pulse latency", h_first, 4);
  endtask

  task automatic t_vcycles();
    do_reset();
    for (int i = 0; i < 320; i++) begin
      @(negedge clk); sample(i);
      vr = (i < 300);
      hr = (i >= 50 && i < 70) || (i >= 150 && i < 160);
    end
    check_eq("R3", "vsync first high sample", v_first, 4);
    check_eq("R5", "vsync width in cycles", v_cnt, VW);
    check_eq("R7", "csync low cycles (NOR)", cs_low, VW + HW);
    check_eq("R7", "csync mismatches", cs_bad, 0);
  endtask

  task automatic t_vlines();
    do_reset();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); sample(i);
      hr = ((i % LINE) < 20);
      vr = (i < 200);
    end
    check_eq("R6", "line-mode vsync start", vl_first, 4);
    check_eq("R6", "line-mode vsync width", vl_cnt, VL * LINE);
    check_eq("R6", "vsync end on hsync leading edge", vl_aligned, 1);
    check_eq("R2", "line-mode hsync pulses", hl_rises, 10);
    check_eq("R7", "csync mismatches", cs_bad, 0);
  endtask

  initial begin
    clr_stats();
    repeat (3) @(negedge clk);
    t_reset();
    t_hwidth();
    t_retrig();
    t_rearm();
    t_vcycles();
    t_vlines();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule